// File: doc/BRIEF.md
# Multi-Successor Block Predictor

This block chooses, once per accepted request, which of up to eight successors should follow a block of operations. Such a block ends in one direction branch, the trap, and may carry up to two early-exit checks, the faults. A target buffer keeps, for each tracked block, a tag, a successor width, and eight successor slots. A global history register combined with a table of small saturating counters yields a 3-bit selector. Bit 0 of the selector is the trap direction. Bits 1 and 2 are the two fault predictions. The chosen slot supplies the predicted next-block address.

Lookups use a valid/ready stream. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. Its prediction is presented one cycle later and stays unchanged until `pred_ready` is high. While an unconsumed prediction is held, `req_ready` is low, so no new request is taken. The three update inputs are single-cycle strobes with no handshake: one installs a newly seen block with its two explicit trap targets, one adds a successor found by a fault mispredict, and one trains the counters with a resolved outcome and repairs the history.

The history advances only by the number of bits the block needs, which is its successor width (1, 2 or 3). A block with two successors therefore adds one bit of history, and history bits are not wasted on fault bits that are forced to zero.

Top module: `blkpred_top`

## Requirements
- R1: A request is accepted when `req_valid && req_ready`. Its prediction has `pred_valid` high on the next cycle. `req_ready` equals `!pred_valid || pred_ready`. While `pred_valid && !pred_ready`, every prediction output stays unchanged.
- R2: After reset, `pred_valid` is 0, `req_ready` is 1, the history is 0, every counter holds 1, and no block is tracked, so every lookup misses.
- R3: An install writes the tag, the width, slot 0 (fall-through target) and slot 1 (taken target), and marks slots 2 to 7 empty. Installing again at the same address replaces the entry.
- R4: A fill writes one slot (0 to 7) and marks it present only when the fill address hits a tracked block. A fill to an untracked address has no effect.
- R5: Selector bit k (0 to 2) is 1 only when k is less than the block's width and counter k is 2 or more. Bits at or above the width are 0.
- R6: On a hit, the target is the slot numbered by the selector when that slot is present. Otherwise it is slot 0 or slot 1, chosen by selector bit 0.
- R7: On a miss, `pred_hit` is 0, the selector and `pred_width` are 0, the target is the request address plus 1, and the history is left unchanged.
- R8: An accepted hit shifts the history left by the width and places the low width bits of the selector at the bottom. A width code of 0 is treated as 1, both at install and at resolve.
- R9: The counter row is selected by the history XOR the low address bits. Counters move by one toward the outcome and saturate at 0 and 3.
- R10: A resolve updates only counters 0 to width-1 of the row given by `res_hist ^ res_pc_lo`. It sets the history to `res_hist` shifted by the width with `res_sel` inserted, and this takes precedence over a lookup shift in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request valid |
| req_ready | output | 1 | Lookup request can be accepted |
| req_addr | input | ADDR_W | Block address to predict from |
| pred_valid | output | 1 | Prediction valid |
| pred_ready | input | 1 | Consumer takes the prediction |
| pred_hit | output | 1 | Block was tracked |
| pred_sel | output | 3 | Successor selector |
| pred_width | output | 2 | History bits used by this block (0 on miss) |
| pred_target | output | ADDR_W | Predicted next-block address |
| pred_hist | output | HIST_W | History value used for this prediction |
| ins_en | input | 1 | Install strobe |
| ins_addr | input | ADDR_W | Block being installed |
| ins_taken | input | ADDR_W | Trap taken target (slot 1) |
| ins_fall | input | ADDR_W | Trap not-taken target (slot 0) |
| ins_width | input | 2 | Log2 of the successor count |
| fill_en | input | 1 | Slot fill strobe |
| fill_addr | input | ADDR_W | Block receiving the slot |
| fill_slot | input | 3 | Slot number (selector value) |
| fill_target | input | ADDR_W | Successor address |
| res_en | input | 1 | Resolve strobe |
| res_pc_lo | input | HIST_W | Low address bits of the resolved block |
| res_hist | input | HIST_W | History captured with that prediction |
| res_sel | input | 3 | Resolved selector |
| res_width | input | 2 | Width of the resolved block |

## Verification
The checker enforces the output handshake on every cycle: prediction outputs stay stable while stalled, and `req_ready` is low while a prediction is held. On every cycle it also checks that selector bits above the width are zero, that a miss reports a zero selector and leaves the history untouched, and that a resolve leaves its trap outcome at the bottom of the history. Several behaviours can only be shown by the bench, because they depend on earlier training and installs. These are the counter thresholds and saturation, the indexing of the counter rows by history, the fallback to a trap slot when the chosen slot is empty, the clearing of slots on reinstall, fills that are ignored on a miss, and the precedence of a resolve over a lookup in the same cycle.

// File: rtl/blkpred_pkg.sv
package blkpred_pkg;
  localparam int SEL_W = 3;
  localparam int NSLOT = 1 << SEL_W;
  localparam int CTR_W = 2;
  localparam int NCTR  = SEL_W;

  typedef logic [CTR_W-1:0] ctr_t;
  localparam ctr_t CTR_INIT = 2'd1;
  localparam ctr_t CTR_MAX  = 2'd3;

  function automatic ctr_t ctr_step(ctr_t c, logic up);
    if (up) return (c == CTR_MAX) ? c : c + 2'd1;
    return (c == 2'd0) ? c : c - 2'd1;
  endfunction

  // width code 0 is handled as a single-bit block
  function automatic logic [1:0] width_fix(logic [1:0] w);
    return (w == 2'd0) ? 2'd1 : w;
  endfunction
endpackage

// File: rtl/blkpred_btb.sv
module blkpred_btb
  import blkpred_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int IDX_W  = 4
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [ADDR_W-1:0]              rd_addr,
  output logic                           rd_hit,
  output logic [1:0]                     rd_width,
  output logic [NSLOT-1:0][ADDR_W-1:0]   rd_tgt,
  output logic [NSLOT-1:0]               rd_tvld,
  input  logic                           ins_en,
  input  logic [ADDR_W-1:0]              ins_addr,
  input  logic [ADDR_W-1:0]              ins_taken,
  input  logic [ADDR_W-1:0]              ins_fall,
  input  logic [1:0]                     ins_width,
  input  logic                           fill_en,
  input  logic [ADDR_W-1:0]              fill_addr,
  input  logic [SEL_W-1:0]               fill_slot,
  input  logic [ADDR_W-1:0]              fill_target
);
  localparam int DEPTH = 1 << IDX_W;
  localparam int TAG_W = ADDR_W - IDX_W;

  typedef struct packed {
    logic                         vld;
    logic [TAG_W-1:0]             tag;
    logic [1:0]                   width;
    logic [NSLOT-1:0]             tvld;
    logic [NSLOT-1:0][ADDR_W-1:0] tgt;
  } ent_t;

  ent_t mem [DEPTH];

  logic [IDX_W-1:0] ridx, iidx, fidx;
  logic             fill_hit;

  assign ridx = rd_addr[IDX_W-1:0];
  assign iidx = ins_addr[IDX_W-1:0];
  assign fidx = fill_addr[IDX_W-1:0];

  assign fill_hit = mem[fidx].vld && (mem[fidx].tag == fill_addr[ADDR_W-1:IDX_W]);

  always_comb begin
    rd_hit   = mem[ridx].vld && (mem[ridx].tag == rd_addr[ADDR_W-1:IDX_W]);
    rd_width = mem[ridx].width;
    rd_tgt   = mem[ridx].tgt;
    rd_tvld  = mem[ridx].tvld;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int e = 0; e < DEPTH; e++) mem[e] <= '0;
    end else begin
      for (int e = 0; e < DEPTH; e++) begin
        if (ins_en && iidx == IDX_W'(e)) begin
          mem[e].vld    <= 1'b1;
          mem[e].tag    <= ins_addr[ADDR_W-1:IDX_W];
          mem[e].width  <= width_fix(ins_width);
          mem[e].tvld   <= NSLOT'(2'b11);
          mem[e].tgt[0] <= ins_fall;
          mem[e].tgt[1] <= ins_taken;
        end else if (fill_en && fill_hit && fidx == IDX_W'(e)) begin
          mem[e].tgt[fill_slot]  <= fill_target;
          mem[e].tvld[fill_slot] <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/blkpred_pht.sv
module blkpred_pht
  import blkpred_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [NCTR-1:0]  rd_dir,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [SEL_W-1:0] wr_sel,
  input  logic [1:0]       wr_width
);
  localparam int DEPTH = 1 << IDX_W;

  ctr_t tab [DEPTH][NCTR];

  always_comb begin
    for (int k = 0; k < NCTR; k++) rd_dir[k] = tab[rd_idx][k][CTR_W-1];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++)
        for (int k = 0; k < NCTR; k++) tab[i][k] <= CTR_INIT;
    end else if (wr_en) begin
      for (int k = 0; k < NCTR; k++)
        if (k < int'(wr_width)) tab[wr_idx][k] <= ctr_step(tab[wr_idx][k], wr_sel[k]);
    end
  end
endmodule

// File: rtl/blkpred_ghr.sv
module blkpred_ghr
  import blkpred_pkg::*;
#(
  parameter int HIST_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_en,
  input  logic [SEL_W-1:0]  push_sel,
  input  logic [1:0]        push_width,
  input  logic              fix_en,
  input  logic [HIST_W-1:0] fix_base,
  input  logic [SEL_W-1:0]  fix_sel,
  input  logic [1:0]        fix_width,
  output logic [HIST_W-1:0] hist
);
  function automatic logic [HIST_W-1:0] push(logic [HIST_W-1:0] b,
                                             logic [SEL_W-1:0] s, logic [1:0] w);
    case (w)
      2'd2:    return {b[HIST_W-3:0], s[1:0]};
      2'd3:    return {b[HIST_W-4:0], s};
      default: return {b[HIST_W-2:0], s[0]};
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)       hist <= '0;
    else if (fix_en)  hist <= push(fix_base, fix_sel, fix_width);
    else if (push_en) hist <= push(hist, push_sel, push_width);
  end
endmodule

// File: rtl/blkpred_top.sv
module blkpred_top
  import blkpred_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int HIST_W    = 8,
  parameter int BTB_IDX_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              pred_valid,
  input  logic              pred_ready,
  output logic              pred_hit,
  output logic [2:0]        pred_sel,
  output logic [1:0]        pred_width,
  output logic [ADDR_W-1:0] pred_target,
  output logic [HIST_W-1:0] pred_hist,
  input  logic              ins_en,
  input  logic [ADDR_W-1:0] ins_addr,
  input  logic [ADDR_W-1:0] ins_taken,
  input  logic [ADDR_W-1:0] ins_fall,
  input  logic [1:0]        ins_width,
  input  logic              fill_en,
  input  logic [ADDR_W-1:0] fill_addr,
  input  logic [2:0]        fill_slot,
  input  logic [ADDR_W-1:0] fill_target,
  input  logic              res_en,
  input  logic [HIST_W-1:0] res_pc_lo,
  input  logic [HIST_W-1:0] res_hist,
  input  logic [2:0]        res_sel,
  input  logic [1:0]        res_width
);
  logic                         lk_fire, lk_hit;
  logic [1:0]                   lk_width, res_w;
  logic [NSLOT-1:0][ADDR_W-1:0] lk_tgt;
  logic [NSLOT-1:0]             lk_tvld;
  logic [NCTR-1:0]              lk_dir;
  logic [SEL_W-1:0]             sel_c;
  logic [ADDR_W-1:0]            tgt_c;
  logic [HIST_W-1:0]            ghr_q;

  assign req_ready = !pred_valid || pred_ready;
  assign lk_fire   = req_valid && req_ready;
  assign res_w     = width_fix(res_width);

  blkpred_btb #(.ADDR_W(ADDR_W), .IDX_W(BTB_IDX_W)) u_btb (
    .clk(clk), .rst_n(rst_n),
    .rd_addr(req_addr), .rd_hit(lk_hit), .rd_width(lk_width),
    .rd_tgt(lk_tgt), .rd_tvld(lk_tvld),
    .ins_en(ins_en), .ins_addr(ins_addr), .ins_taken(ins_taken),
    .ins_fall(ins_fall), .ins_width(ins_width),
    .fill_en(fill_en), .fill_addr(fill_addr), .fill_slot(fill_slot),
    .fill_target(fill_target)
  );

  blkpred_pht #(.IDX_W(HIST_W)) u_pht (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(ghr_q ^ req_addr[HIST_W-1:0]), .rd_dir(lk_dir),
    .wr_en(res_en), .wr_idx(res_hist ^ res_pc_lo),
    .wr_sel(res_sel), .wr_width(res_w)
  );

  blkpred_ghr #(.HIST_W(HIST_W)) u_ghr (
    .clk(clk), .rst_n(rst_n),
    .push_en(lk_fire && lk_hit), .push_sel(sel_c), .push_width(lk_width),
    .fix_en(res_en), .fix_base(res_hist), .fix_sel(res_sel), .fix_width(res_w),
    .hist(ghr_q)
  );

  always_comb begin
    for (int k = 0; k < SEL_W; k++)
      sel_c[k] = lk_hit && (k < int'(lk_width)) && lk_dir[k];
    if (!lk_hit)             tgt_c = req_addr + ADDR_W'(1);
    else if (lk_tvld[sel_c]) tgt_c = lk_tgt[sel_c];
    else                     tgt_c = lk_tgt[{2'b00, sel_c[0]}];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pred_valid  <= 1'b0;
      pred_hit    <= 1'b0;
      pred_sel    <= '0;
      pred_width  <= '0;
      pred_target <= '0;
      pred_hist   <= '0;
    end else if (lk_fire) begin
      pred_valid  <= 1'b1;
      pred_hit    <= lk_hit;
      pred_sel    <= sel_c;
      pred_width  <= lk_hit ? lk_width : 2'd0;
      pred_target <= tgt_c;
      pred_hist   <= ghr_q;
    end else if (pred_ready) begin
      pred_valid  <= 1'b0;
    end
  end
endmodule

// File: rtl/blkpred_chk.sv
module blkpred_chk #(
  parameter int ADDR_W = 16,
  parameter int HIST_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              pred_valid,
  input logic              pred_ready,
  input logic              pred_hit,
  input logic [2:0]        pred_sel,
  input logic [1:0]        pred_width,
  input logic [ADDR_W-1:0] pred_target,
  input logic [HIST_W-1:0] pred_hist,
  input logic              res_en,
  input logic              res_sel0,
  input logic              lk_hit,
  input logic [HIST_W-1:0] ghr
);
  // R1
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pred_valid && !pred_ready |=> pred_valid && $stable(pred_target) &&
      $stable(pred_sel) && $stable(pred_hist) && $stable(pred_hit) && $stable(pred_width));

  // R1
  ready_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pred_valid && !pred_ready |-> !req_ready);

  // R5
  sel_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pred_valid && pred_hit |-> 3'(pred_sel >> pred_width) == 3'd0);

  // R7
  miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pred_valid && !pred_hit |-> pred_sel == 3'd0 && pred_width == 2'd0);

  // R7
  miss_hist_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && !lk_hit && !res_en |=> $stable(ghr));

  // R10
  repair_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_en |=> ghr[0] == $past(res_sel0));
endmodule

bind blkpred_top blkpred_chk #(.ADDR_W(ADDR_W), .HIST_W(HIST_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .pred_valid(pred_valid), .pred_ready(pred_ready), .pred_hit(pred_hit),
  .pred_sel(pred_sel), .pred_width(pred_width), .pred_target(pred_target),
  .pred_hist(pred_hist), .res_en(res_en), .res_sel0(res_sel[0]),
  .lk_hit(lk_hit), .ghr(ghr_q)
);

// File: tb/blkpred_top_bench.sv
`timescale 1ns/1ps
module blkpred_top_bench;
  localparam int AW = 16;
  localparam int HW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0, pred_ready = 1'b1;
  logic [AW-1:0] req_addr = '0;
  logic          req_ready, pred_valid, pred_hit;
  logic [2:0]    pred_sel;
  logic [1:0]    pred_width;
  logic [AW-1:0] pred_target;
  logic [HW-1:0] pred_hist;
  logic          ins_en = 1'b0, fill_en = 1'b0, res_en = 1'b0;
  logic [AW-1:0] ins_addr = '0, ins_taken = '0, ins_fall = '0;
  logic [1:0]    ins_width = '0, res_width = '0;
  logic [AW-1:0] fill_addr = '0, fill_target = '0;
  logic [2:0]    fill_slot = '0, res_sel = '0;
  logic [HW-1:0] res_pc_lo = '0, res_hist = '0;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  blkpred_top #(.ADDR_W(AW), .HIST_W(HW), .BTB_IDX_W(4)) u_blkpred_top (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .pred_valid(pred_valid), .pred_ready(pred_ready), .pred_hit(pred_hit),
    .pred_sel(pred_sel), .pred_width(pred_width), .pred_target(pred_target),
    .pred_hist(pred_hist),
    .ins_en(ins_en), .ins_addr(ins_addr), .ins_taken(ins_taken),
    .ins_fall(ins_fall), .ins_width(ins_width),
    .fill_en(fill_en), .fill_addr(fill_addr), .fill_slot(fill_slot),
    .fill_target(fill_target),
    .res_en(res_en), .res_pc_lo(res_pc_lo), .res_hist(res_hist),
    .res_sel(res_sel), .res_width(res_width)
  );

  localparam logic [1:0] OP_INS = 2'd0, OP_FIL = 2'd1, OP_RES = 2'd2, OP_LKP = 2'd3;

  typedef struct packed {
    logic [1:0]    op;
    logic [AW-1:0] addr;
    logic [AW-1:0] a;     // INS taken / FIL slot / RES selector
    logic [AW-1:0] b;     // INS fall-through / FIL target
    logic [1:0]    w;
    logic [HW-1:0] h;
    logic          hit;
    logic [2:0]    sel;
    logic [AW-1:0] tgt;
    logic [HW-1:0] hist;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VEC [NV] = '{
    '{OP_LKP, 16'h0010, 16'h0000, 16'h0000, 2'd0, 8'h00, 1'b0, 3'd0, 16'h0011, 8'h00}, // R2 empty
    '{OP_INS, 16'h0010, 16'h0100, 16'h0011, 2'd1, 8'h00, 1'b0, 3'd0, 16'h0000, 8'h00},
    '{OP_LKP, 16'h0010, 16'h0000, 16'h0000, 2'd0, 8'h00, 1'b1, 3'd0, 16'h0011, 8'h00}, // R3 slot0
    '{OP_RES, 16'h0010, 16'h0001, 16'h0000, 2'd1, 8'h00, 1'b0, 3'd0, 16'h0000, 8'h00},
    '{OP_RES, 16'h0010, 16'h0001, 16'h0000, 2'd1, 8'h00, 1'b0, 3'd0, 16'h0000, 8'h00},
    '{OP_LKP, 16'h0011, 16'h0000, 16'h0000, 2'd0, 8'h00, 1'b0, 3'd0, 16'h0012, 8'h01}, // R7, R10 repair
    '{OP_INS, 16'h0011, 16'h0200, 16'h0012, 2'd3, 8'h00, 1'b0, 3'd0, 16'h0000, 8'h00},
    '{OP_LKP, 16'h0011, 16'h0000, 16'h0000, 2'd0, 8'h00, 1'b1, 3'd1, 16'h0200, 8'h01}, // R9 index
    '{OP_RES, 16'h0011, 16'h0007, 16'h0000, 2'd3, 8'h01, 1'b0, 3'd0, 16'h0000, 8'h00},
    '{OP_RES, 16'h0011, 16'h0001, 16'h0000, 2'd1, 8'h00, 1'b0, 3'd0, 16'h0000, 8'h00},
    '{OP_LKP, 16'h0011, 16'h0000, 16'h0000, 2'd0, 8'h00, 1'b1, 3'd7, 16'h0200, 8'h01}, // R6 fallback
    '{OP_FIL, 16'h0011, 16'h0007, 16'h0777, 2'd0, 8'h00, 1'b0, 3'd0, 16'h0000, 8'h00},
    '{OP_RES, 16'h0011, 16'h0001, 16'h0000, 2'd1, 8'h00, 1'b0, 3'd0, 16'h0000, 8'h00},
    '{OP_LKP, 16'h0011, 16'h0000, 16'h0000, 2'd0, 8'h00, 1'b1, 3'd7, 16'h0777, 8'h01}, // R4 fill
    '{OP_LKP, 16'h0055, 16'h0000, 16'h0000, 2'd0, 8'h00, 1'b0, 3'd0, 16'h0056, 8'h0F}, // R8 3-bit
    '{OP_INS, 16'h0011, 16'h0300, 16'h0012, 2'd2, 8'h00, 1'b0, 3'd0, 16'h0000, 8'h00},
    '{OP_RES, 16'h0011, 16'h0001, 16'h0000, 2'd1, 8'h00, 1'b0, 3'd0, 16'h0000, 8'h00},
    '{OP_LKP, 16'h0011, 16'h0000, 16'h0000, 2'd0, 8'h00, 1'b1, 3'd3, 16'h0300, 8'h01}, // R5 mask, R3 clear
    '{OP_FIL, 16'h0055, 16'h0002, 16'h0999, 2'd0, 8'h00, 1'b0, 3'd0, 16'h0000, 8'h00},
    '{OP_LKP, 16'h0055, 16'h0000, 16'h0000, 2'd0, 8'h00, 1'b0, 3'd0, 16'h0056, 8'h07}, // R4 ignored
    '{OP_LKP, 16'h0010, 16'h0000, 16'h0000, 2'd0, 8'h00, 1'b1, 3'd0, 16'h0011, 8'h07},
    '{OP_LKP, 16'h0010, 16'h0000, 16'h0000, 2'd0, 8'h00, 1'b1, 3'd0, 16'h0011, 8'h0E}  // R8 1-bit
  };

  task automatic check(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic lookup(input logic [AW-1:0] addr);
    @(negedge clk);
    req_valid = 1'b1;
    req_addr  = addr;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic check_pred(input string tag, input logic hit, input logic [2:0] sel,
                            input logic [AW-1:0] tgt, input logic [HW-1:0] hist);
    check(pred_valid && pred_hit == hit && pred_sel == sel &&
          pred_target == tgt && pred_hist == hist, tag,
          {pred_valid, 7'd0, pred_hit, 3'd0, pred_sel, pred_target, 8'd0, pred_hist, 16'd0},
          {1'b1, 7'd0, hit, 3'd0, sel, tgt, 8'd0, hist, 16'd0});
  endtask

  task automatic do_ins(input logic [AW-1:0] addr, input logic [AW-1:0] tk,
                        input logic [AW-1:0] ft, input logic [1:0] w);
    @(negedge clk);
    ins_en = 1'b1; ins_addr = addr; ins_taken = tk; ins_fall = ft; ins_width = w;
    @(negedge clk);
    ins_en = 1'b0;
  endtask

  task automatic do_fill(input logic [AW-1:0] addr, input logic [2:0] slot, input logic [AW-1:0] tgt);
    @(negedge clk);
    fill_en = 1'b1; fill_addr = addr; fill_slot = slot; fill_target = tgt;
    @(negedge clk);
    fill_en = 1'b0;
  endtask

  task automatic do_res(input logic [HW-1:0] lo, input logic [2:0] sel,
                        input logic [1:0] w, input logic [HW-1:0] h);
    @(negedge clk);
    res_en = 1'b1; res_pc_lo = lo; res_sel = sel; res_width = w; res_hist = h;
    @(negedge clk);
    res_en = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R2 reset state at the ports
    check(!pred_valid && req_ready, "R2 reset handshake", {pred_valid, req_ready}, 2'b01);

    for (int i = 0; i < NV; i++) begin
      case (VEC[i].op)
        OP_INS: do_ins(VEC[i].addr, VEC[i].a, VEC[i].b, VEC[i].w);
        OP_FIL: do_fill(VEC[i].addr, VEC[i].a[2:0], VEC[i].b);
        OP_RES: do_res(VEC[i].addr[HW-1:0], VEC[i].a[2:0], VEC[i].w, VEC[i].h);
        default: begin
          lookup(VEC[i].addr);
          check_pred($sformatf("R5/R6/R7/R8 vector %0d", i),
                     VEC[i].hit, VEC[i].sel, VEC[i].tgt, VEC[i].hist);
        end
      endcase
    end

    // R1 back-pressure: prediction held, no new request taken
    @(negedge clk);
    pred_ready = 1'b0;
    req_valid  = 1'b1;
    req_addr   = 16'h0055;
    @(negedge clk);
    req_addr   = 16'h0010;
    check(pred_valid && !req_ready && pred_target == 16'h0056, "R1 stall first cycle",
          {pred_valid, req_ready, pred_target}, {1'b1, 1'b0, 16'h0056});
    @(negedge clk);
    check(pred_valid && !req_ready && pred_target == 16'h0056 && !pred_hit, "R1 stall held",
          {pred_valid, req_ready, pred_target}, {1'b1, 1'b0, 16'h0056});
    req_valid  = 1'b0;
    pred_ready = 1'b1;
    @(negedge clk);
    check(!pred_valid && req_ready, "R1 drained", {pred_valid, req_ready}, 2'b01);

    // R10 resolve wins over a same-cycle lookup shift
    @(negedge clk);
    req_valid = 1'b1; req_addr = 16'h0011;
    res_en = 1'b1; res_pc_lo = 8'h11; res_sel = 3'd1; res_width = 2'd1; res_hist = 8'h40;
    @(negedge clk);
    req_valid = 1'b0; res_en = 1'b0;
    lookup(16'h0055);
    check_pred("R10 repair priority", 1'b0, 3'd0, 16'h0056, 8'h81);

    // R8 width code 0 installs as width 1
    do_ins(16'h0033, 16'h0444, 16'h0034, 2'd0);
    lookup(16'h0033);
    check_pred("R8 width0 lookup", 1'b1, 3'd0, 16'h0034, 8'h81);
    check(pred_width == 2'd1, "R8 width0 reported", pred_width, 2'd1);
    lookup(16'h0055);
    check_pred("R8 width0 one-bit shift", 1'b0, 3'd0, 16'h0056, 8'h02);

    // R9 saturation at 0: two not-taken resolves from 1 then one taken stays below threshold
    do_ins(16'h0044, 16'h0A00, 16'h0045, 2'd1);
    do_res(8'h44, 3'd0, 2'd1, 8'h00);
    do_res(8'h44, 3'd0, 2'd1, 8'h00);
    do_res(8'h44, 3'd1, 2'd1, 8'h00);
    do_res(8'h44, 3'd0, 2'd1, 8'h80);  // history becomes 0x00
    lookup(16'h0044);
    check_pred("R9 low saturation", 1'b1, 3'd0, 16'h0045, 8'h00);

    finish_run();
  end
endmodule